// File: doc/BRIEF.md
# PWM Duty Fade Engine

This block drives one pulse-width-modulated output from a free-running period counter and a duty level, and can move that duty level on its own in equal steps so that the output brightens or dims smoothly without software touching every step. A ramp is described by one 32-bit configuration word: how much each step moves the duty, how many PWM periods pass between steps, how many steps to take, and which way to go. The top bit of the word is a one-shot start command. A ramp begins only when a word carrying that bit is written.

A separate write port loads a starting duty level directly. Every change to the duty, whether it comes from a direct load or from a ramp step, is held back until the period counter wraps. Because of this, a pulse that has begun always runs to its full length. The block raises a one-clock completion pulse in the cycle that the final step of a ramp reaches the output. Both write ports are plain single-cycle strobes with no back-pressure, because each write is accepted in the clock cycle in which it is presented.

Top module: `pwm_fade_engine`

## Requirements
- R1: The configuration word is decoded as step size in bits 9:0, step interval in bits 19:10, step count in bits 29:20, direction in bit 30 (1 = increase, 0 = decrease) and start in bit 31.
- R2: The period counter is 0 in the first cycle after reset and counts up by one every clock, wrapping from 2^DUTY_W-1 to 0. `pwm_out` is high exactly in the cycles where the counter is less than `duty_now`.
- R3: A value written on the direct duty port appears on `duty_now` in the cycle the counter returns to 0, and not before.
- R4: A configuration write with bit 31 clear changes neither `duty_now` nor `ramp_done`.
- R5: After a start, every step interval periods the duty moves by the step size in the chosen direction. The first step shows at the interval-th counter wrap after the start.
- R6: The start bit acts once. A ramp takes exactly step-count steps and then holds its final duty, and a started ramp does not repeat on its own.
- R7: Increasing stops at 2^DUTY_W-1 and decreasing stops at 0. The duty never wraps around.
- R8: A step interval of 0 behaves as 1. A step count of 0 completes at once: `ramp_done` pulses in the cycle after the start write, and the duty is unchanged.
- R9: `ramp_done` is high for exactly one clock per completed ramp, in the same cycle that the last step appears on `duty_now`.
- R10: A start written while a ramp is running abandons that ramp and begins the new one from the current duty with the new settings.
- R11: After reset `duty_now` is 0, `pwm_out` is low, `ramp_done` is low and no ramp is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word (fields per R1) |
| duty_we | input | 1 | Direct duty write strobe |
| duty_wdata | input | DUTY_W (10) | Duty level to load at the next period wrap |
| pwm_out | output | 1 | PWM output |
| duty_now | output | DUTY_W (10) | Duty level currently compared against the counter |
| ramp_done | output | 1 | One-clock pulse when a ramp completes |

## Verification
Because `duty_now` changes only at a counter wrap, a wrong step size, a wrong direction or a missed clamp shows up in the first cycle of the next period, and the bench checks `duty_now` at every period start of every ramp. If the interval counter or the remaining-step count is corrupted, a step lands one or more whole periods early or late, or the ramp stops at the wrong level. This appears within one interval as a mismatch in `duty_now` or a misplaced `ramp_done`. The bench sweeps interval, count and direction over small values and also runs saturating and restarted ramps. Errors in the comparator or the counter appear as a wrong high-cycle count within a single period.

// File: rtl/pwm_fade_pkg.sv
package pwm_fade_pkg;
  localparam int FIELD_W = 10;

  // Field order follows bit position, MSB first (R1)
  typedef struct packed {
    logic               start;
    logic               dir_up;
    logic [FIELD_W-1:0] count;
    logic [FIELD_W-1:0] interval;
    logic [FIELD_W-1:0] size;
  } fade_cfg_t;

  localparam logic [31:0] CFG_RESET = 32'h4000_0000;
endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + ONE;
  end

  assign wrap = &cnt;
endmodule

// File: rtl/pwm_ramp_ctrl.sv
module pwm_ramp_ctrl
  import pwm_fade_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  fade_cfg_t          cfg,
  input  logic               wrap,
  output logic               step_en,
  output logic               step_up,
  output logic [FIELD_W-1:0] step_size,
  output logic               running,
  output logic               done
);
  localparam logic [FIELD_W-1:0] ONE = {{(FIELD_W-1){1'b0}}, 1'b1};
  localparam fade_cfg_t RST_CFG = fade_cfg_t'(CFG_RESET);

  logic [FIELD_W-1:0] ivl_q;
  logic [FIELD_W-1:0] per_q;
  logic [FIELD_W-1:0] left_q;
  logic               last_per;

  assign last_per = (per_q == ivl_q - ONE);
  assign step_en  = running && wrap && last_per && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      ivl_q     <= ONE;
      per_q     <= '0;
      left_q    <= '0;
      step_up   <= RST_CFG.dir_up;
      step_size <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        running   <= (cfg.count != '0);
        ivl_q     <= (cfg.interval == '0) ? ONE : cfg.interval;
        per_q     <= '0;
        left_q    <= cfg.count;
        step_up   <= cfg.dir_up;
        step_size <= cfg.size;
        done      <= (cfg.count == '0);
      end else if (running && wrap) begin
        if (last_per) begin
          per_q  <= '0;
          left_q <= left_q - ONE;
          if (left_q == ONE) begin
            running <= 1'b0;
            done    <= 1'b1;
          end
        end else begin
          per_q <= per_q + ONE;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_duty_unit.sv
module pwm_duty_unit
  import pwm_fade_pkg::*;
#(
  parameter int DUTY_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DUTY_W-1:0]  wr_val,
  input  logic               wrap,
  input  logic               step_en,
  input  logic               step_up,
  input  logic [FIELD_W-1:0] step_size,
  output logic [DUTY_W-1:0]  duty,
  output logic               direct_load
);
  localparam int SW = ((DUTY_W > FIELD_W) ? DUTY_W : FIELD_W) + 1;
  localparam logic [SW-1:0] FULL = {{(SW-DUTY_W){1'b0}}, {DUTY_W{1'b1}}};

  logic [SW-1:0]     ext_duty, ext_size, sum, stepped;
  logic              pend_q;
  logic [DUTY_W-1:0] pend_val_q;
  logic              have_wr;
  logic [DUTY_W-1:0] wr_pick;

  assign ext_duty = {{(SW-DUTY_W){1'b0}}, duty};
  assign ext_size = {{(SW-FIELD_W){1'b0}}, step_size};
  assign sum      = ext_duty + ext_size;

  always_comb begin
    if (step_up) stepped = (sum > FULL) ? FULL : sum;
    else         stepped = (ext_size > ext_duty) ? '0 : (ext_duty - ext_size);
  end

  assign have_wr     = wr_en || pend_q;
  assign wr_pick     = wr_en ? wr_val : pend_val_q;
  assign direct_load = wrap && have_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty       <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else if (wrap) begin
      pend_q <= 1'b0;
      if (have_wr)      duty <= wr_pick;
      else if (step_en) duty <= stepped[DUTY_W-1:0];
    end else if (wr_en) begin
      pend_q     <= 1'b1;
      pend_val_q <= wr_val;
    end
  end
endmodule

// File: rtl/pwm_fade_engine.sv
module pwm_fade_engine
  import pwm_fade_pkg::*;
#(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              duty_we,
  input  logic [DUTY_W-1:0] duty_wdata,
  output logic              pwm_out,
  output logic [DUTY_W-1:0] duty_now,
  output logic              ramp_done
);
  fade_cfg_t          cfg_w;
  logic               start_w;
  logic [DUTY_W-1:0]  cnt_w;
  logic               wrap_w;
  logic               step_en_w, step_up_w, running_w, direct_load_w;
  logic [FIELD_W-1:0] step_size_w;

  assign cfg_w   = fade_cfg_t'(cfg_wdata);
  assign start_w = cfg_we && cfg_w.start;

  pwm_period_ctr #(.W(DUTY_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt  (cnt_w),
    .wrap (wrap_w)
  );

  pwm_ramp_ctrl u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_w),
    .cfg      (cfg_w),
    .wrap     (wrap_w),
    .step_en  (step_en_w),
    .step_up  (step_up_w),
    .step_size(step_size_w),
    .running  (running_w),
    .done     (ramp_done)
  );

  pwm_duty_unit #(.DUTY_W(DUTY_W)) u_duty (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (duty_we),
    .wr_val     (duty_wdata),
    .wrap       (wrap_w),
    .step_en    (step_en_w),
    .step_up    (step_up_w),
    .step_size  (step_size_w),
    .duty       (duty_now),
    .direct_load(direct_load_w)
  );

  assign pwm_out = (cnt_w < duty_now);
endmodule

// File: rtl/pwm_fade_chk.sv
module pwm_fade_chk #(
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DUTY_W-1:0] cnt,
  input logic              wrap,
  input logic [DUTY_W-1:0] duty_now,
  input logic              pwm_out,
  input logic              ramp_done,
  input logic              running,
  input logic              step_en,
  input logic              step_up,
  input logic              direct_load
);
  localparam logic [DUTY_W-1:0] ONE = {{(DUTY_W-1){1'b0}}, 1'b1};

  // R2
  cnt_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (cnt == $past(cnt) + ONE));

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  // R2
  pwm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_now == '0) |-> !pwm_out);

  // R3
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_now));

  // R7
  sat_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && !direct_load) |=> (duty_now >= $past(duty_now)));

  // R7
  sat_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_up && !direct_load) |=> (duty_now <= $past(duty_now)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |=> !ramp_done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |-> !running);
endmodule

bind pwm_fade_engine pwm_fade_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt        (cnt_w),
  .wrap       (wrap_w),
  .duty_now   (duty_now),
  .pwm_out    (pwm_out),
  .ramp_done  (ramp_done),
  .running    (running_w),
  .step_en    (step_en_w),
  .step_up    (step_up_w),
  .direct_load(direct_load_w)
);

// File: tb/tb_pwm_fade_engine.sv
module tb_pwm_fade_engine;
  localparam int DW  = 10;
  localparam int PER = 1 << DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic          duty_we = 1'b0;
  logic [DW-1:0] duty_wdata = '0;
  logic          pwm_out, ramp_done;
  logic [DW-1:0] duty_now;

  int checks = 0;
  int fails = 0;
  int mcnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwm_fade_engine #(.DUTY_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata),
    .pwm_out(pwm_out), .duty_now(duty_now), .ramp_done(ramp_done)
  );

  // Bench model of the period counter from R2
  always @(posedge clk) begin
    if (!rst_n) mcnt <= 0;
    else        mcnt <= (mcnt + 1) % PER;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cnt(input int v);
    do @(negedge clk); while (mcnt != v);
  endtask

  function automatic int fade_model(input int d0, input int s, input int k, input int up);
    int v;
    v = up ? d0 + s * k : d0 - s * k;
    if (v > PER - 1) v = PER - 1;
    if (v < 0) v = 0;
    return v;
  endfunction

  // Direct load, applied only at the wrap (R3)
  task automatic set_duty(input int v);
    int old;
    wait_cnt(200);
    old = duty_now;
    duty_we = 1'b1;
    duty_wdata = v[DW-1:0];
    @(negedge clk);
    duty_we = 1'b0;
    chk("R3 duty held right after write", duty_now, old);
    wait_cnt(PER - 1);
    chk("R3 duty held until last count", duty_now, old);
    wait_cnt(0);
    chk("R3 duty applied at wrap", duty_now, v);
  endtask

  task automatic ramp(input string tag, input int d0, input int s, input int ivl,
                      input int n, input int up, input bit load);
    int bidx, dcnt, dat, ie, tot, k;
    if (load) set_duty(d0);
    wait_cnt(100);
    cfg_wdata = {1'b1, up[0], n[9:0], ivl[9:0], s[9:0]};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = '0;
    bidx = 0; dcnt = 0; dat = -1;
    if (ramp_done) begin dcnt++; dat = 0; end
    ie  = (ivl == 0) ? 1 : ivl;
    tot = (n == 0) ? 1 : ie * n + 1;
    while (bidx < tot) begin
      @(negedge clk);
      if (mcnt == 0) begin
        bidx++;
        k = bidx / ie;
        if (k > n) k = n;
        chk({tag, " duty at period start"}, duty_now, fade_model(d0, s, k, up));
      end
      if (ramp_done) begin dcnt++; dat = bidx; end
    end
    chk({tag, " R9 done pulse count"}, dcnt, 1);
    chk({tag, " R9 done position"}, dat, (n == 0) ? 0 : ie * n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi, mism, dc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 duty after reset", duty_now, 0);
    chk("R11 pwm after reset", pwm_out, 0);
    chk("R11 done after reset", ramp_done, 0);

    // R2 compare sweep over several duty levels
    foreach (dc_list[i]) begin
      set_duty(dc_list[i]);
      hi = 0; mism = 0;
      for (int c = 0; c < PER; c++) begin
        if (pwm_out) hi++;
        if (pwm_out !== (mcnt < dc_list[i])) mism++;
        @(negedge clk);
      end
      chk("R2 per-cycle mismatches", mism, 0);
      chk("R2 high cycles per period", hi, dc_list[i]);
    end

    // R4 configuration without start has no effect
    set_duty(400);
    wait_cnt(100);
    cfg_wdata = {1'b0, 1'b1, 10'd1, 10'd1, 10'd100};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    dc = 0;
    for (int c = 0; c < 2 * PER; c++) begin
      if (ramp_done) dc++;
      @(negedge clk);
    end
    chk("R4 duty unchanged", duty_now, 400);
    chk("R4 no done", dc, 0);

    // R5 R6 R1 basic ramps
    ramp("R5 up", 100, 50, 1, 4, 1, 1'b1);
    ramp("R6 down ivl2", 200, 30, 2, 3, 0, 1'b1);
    // R7 saturation
    ramp("R7 up clamp", 500, 400, 1, 5, 1, 1'b1);
    ramp("R7 down clamp", 150, 100, 1, 4, 0, 1'b1);

    // R1 R8 sweep of interval, count and direction
    for (int up = 0; up < 2; up++)
      for (int iv = 0; iv <= 2; iv += 2)
        for (int nn = 0; nn < 4; nn++)
          if (nn != 2) ramp("R8 R1 sweep", 500, 7, iv, nn, up, 1'b1);

    // R10 restart while running
    set_duty(0);
    wait_cnt(100);
    cfg_wdata = {1'b1, 1'b1, 10'd10, 10'd1, 10'd10};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_cnt(0);
    wait_cnt(0);
    chk("R10 first ramp progress", duty_now, 20);
    ramp("R10 restart", 20, 5, 1, 2, 0, 1'b0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int dc_list[5] = '{0, 1, 300, 512, 1023};
endmodule